// File: doc/BRIEF.md
# Field Correlation Movie-Phase Detector

This block measures how much two successive video fields differ, so that a controller can tell film-originated material from native video. It receives two 8-bit luminance streams, one for each field, which arrive on the same clock. An active-video qualifier, taken from the blanking signal, limits the measurement to the visible picture.

For each qualified pixel, the block takes the absolute difference of the upper four luminance bits of the two streams. It adds that difference to a wide running sum. During field blanking an external strobe arrives, asynchronous to the pixel clock. On the strobe's rising edge, the top 16 bits of the sum move into a result register and the sum starts again from zero.

The host reads the result through a byte-wide read port. The low byte sits at address 0x80 and the high byte at 0x81. Reading the high byte clears the result, so the host reads the low byte first.

Top module: `field_corr_detect`

## Requirements
- R1: A pixel adds to the sum only when `active_vid` is 1 in the cycle it is presented; pixels with `active_vid` at 0 leave the sum unchanged.
- R2: The amount added per pixel is |luma_a[7:4] − luma_b[7:4]| (0..15); bits 3..0 of both inputs have no effect.
- R3: The running sum is 22 bits wide and never wraps within a field; a field of 20000 maximum-difference pixels (sum 300000) gives a result of 300000 >> 6 = 0x124F.
- R4: On a transfer, the result register takes sum bits 21..6 and the sum restarts from zero, so each result covers only the pixels since the previous transfer.
- R5: `fld_strobe` passes through a two-flop synchroniser and a rising-edge detector; one rising edge gives exactly one transfer, no matter how long the strobe stays high, and the new result is readable from the fourth clock edge after the strobe rises.
- R6: A read request (`rd_en`=1) at address 0x80 returns result bits 7..0 on `rd_data`, with `rd_valid`=1, in the cycle after the request.
- R7: A read request at address 0x81 returns result bits 15..8 in the same way, pulses `rd_done` for that one cycle, and clears the result register to zero.
- R8: Reading address 0x80 does not change the result register.
- R9: A read request at any other address leaves `rd_valid` and `rd_done` at 0 and does not change the result register.
- R10: Synchronous reset brings the sum, the result register, the synchroniser and all read outputs to zero.
- R11: When a transfer and a high-byte read fall in the same cycle, the read returns the old high byte and the newly transferred value is kept; the clear is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| active_vid | input | 1 | 1 during active video, 0 during blanking |
| luma_a | input | 8 | Luminance of the current field |
| luma_b | input | 8 | Luminance of the previous field, same position |
| fld_strobe | input | 1 | Asynchronous transfer strobe, rising edge transfers |
| rd_en | input | 1 | Host read request, one cycle |
| rd_addr | input | 8 | Host read address (0x80 low byte, 0x81 high byte) |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | `rd_data` holds a valid byte |
| rd_done | output | 1 | One-cycle pulse after a high-byte read |

## Verification
The hardest situation to reach from the ports is a high-byte read landing in the same cycle as a transfer. The strobe enters asynchronously and only acts after the synchroniser, so a host would hit this case only by chance. The bench raises the strobe just before a known clock edge and counts the two synchroniser edges. It then places the 0x81 request so that it is sampled on the edge where the transfer happens, and checks that the old high byte is returned and the new result survives. A second hard case is a strobe held high while active pixels keep arriving. A further read then shows that no second transfer took place.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int unsigned FCD_PIX_W  = 8;
  localparam int unsigned FCD_CMP_W  = 4;
  localparam int unsigned FCD_ACC_W  = 22;
  localparam int unsigned FCD_RES_W  = 16;
  localparam int unsigned FCD_ADDR_W = 8;
  localparam logic [FCD_ADDR_W-1:0] FCD_LO_ADDR = 8'h80;
  localparam logic [FCD_ADDR_W-1:0] FCD_HI_ADDR = 8'h81;
endpackage

// File: rtl/fcd_sync_edge.sv
module fcd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fcd_diff_stage.sv
module fcd_diff_stage #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned CMP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vid_in,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  output logic [CMP_W-1:0] diff_q,
  output logic             valid_q
);
  logic [CMP_W-1:0] a_hi, b_hi, mag;

  assign a_hi = pix_a[PIX_W-1 -: CMP_W];
  assign b_hi = pix_b[PIX_W-1 -: CMP_W];

  always_comb begin
    if (a_hi >= b_hi) mag = a_hi - b_hi;
    else              mag = b_hi - a_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      diff_q  <= mag;
      valid_q <= vid_in;
    end
  end
endmodule

// File: rtl/fcd_accum.sv
module fcd_accum #(
  parameter int unsigned CMP_W = 4,
  parameter int unsigned ACC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [CMP_W-1:0] diff,
  input  logic             restart,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] addend;

  assign addend = valid ? ACC_W'(diff) : '0;

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (restart) acc_q <= addend;
    else              acc_q <= acc_q + addend;
  end
endmodule

// File: rtl/fcd_result.sv
module fcd_result #(
  parameter int unsigned ACC_W  = 22,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h80,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h81
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  xfer,
  input  logic [ACC_W-1:0]      acc,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [RES_W/2-1:0]    rd_data,
  output logic                  rd_valid,
  output logic                  rd_done,
  output logic [RES_W-1:0]      result_q
);
  localparam int unsigned BYTE_W = RES_W / 2;

  logic lo_hit, hi_hit;

  assign lo_hit = rd_en && (rd_addr == LO_ADDR);
  assign hi_hit = rd_en && (rd_addr == HI_ADDR);

  // transfer has priority over the clear that follows a high-byte read
  always_ff @(posedge clk) begin
    if (rst)         result_q <= '0;
    else if (xfer)   result_q <= acc[ACC_W-1 -: RES_W];
    else if (hi_hit) result_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      rd_valid <= lo_hit | hi_hit;
      rd_done  <= hi_hit;
      if (hi_hit)      rd_data <= result_q[RES_W-1 -: BYTE_W];
      else if (lo_hit) rd_data <= result_q[BYTE_W-1:0];
      else             rd_data <= '0;
    end
  end
endmodule

// File: rtl/field_corr_detect.sv
module field_corr_detect
  import fcd_pkg::*;
#(
  parameter int unsigned PIX_W       = FCD_PIX_W,
  parameter int unsigned CMP_W       = FCD_CMP_W,
  parameter int unsigned ACC_W       = FCD_ACC_W,
  parameter int unsigned RES_W       = FCD_RES_W,
  parameter int unsigned ADDR_W      = FCD_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LO_ADDR = FCD_LO_ADDR,
  parameter logic [ADDR_W-1:0] HI_ADDR = FCD_HI_ADDR
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active_vid,
  input  logic [PIX_W-1:0]   luma_a,
  input  logic [PIX_W-1:0]   luma_b,
  input  logic               fld_strobe,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [RES_W/2-1:0] rd_data,
  output logic               rd_valid,
  output logic               rd_done
);
  logic             xfer_pulse;
  logic [CMP_W-1:0] pix_diff;
  logic             pix_valid;
  logic [ACC_W-1:0] acc_sum;
  logic [RES_W-1:0] result_q;

  fcd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(fld_strobe), .rise(xfer_pulse)
  );

  fcd_diff_stage #(.PIX_W(PIX_W), .CMP_W(CMP_W)) u_diff (
    .clk(clk), .rst(rst), .vid_in(active_vid),
    .pix_a(luma_a), .pix_b(luma_b),
    .diff_q(pix_diff), .valid_q(pix_valid)
  );

  fcd_accum #(.CMP_W(CMP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .valid(pix_valid), .diff(pix_diff),
    .restart(xfer_pulse), .acc_q(acc_sum)
  );

  fcd_result #(
    .ACC_W(ACC_W), .RES_W(RES_W), .ADDR_W(ADDR_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_res (
    .clk(clk), .rst(rst), .xfer(xfer_pulse), .acc(acc_sum),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done),
    .result_q(result_q)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned CMP_W  = 4,
  parameter int unsigned ACC_W  = 22,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h80,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h81
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_pulse,
  input logic              pix_valid,
  input logic [ACC_W-1:0]  acc_sum,
  input logic [RES_W-1:0]  result_q,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              rd_done
);
  p_blank_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!pix_valid && !xfer_pulse) |=> $stable(acc_sum));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    !xfer_pulse |=> (acc_sum >= $past(acc_sum)));

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |=> (acc_sum <= ACC_W'((1 << CMP_W) - 1)));

  p_latch_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |=> (result_q == $past(acc_sum[ACC_W-1 -: RES_W])));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |=> !xfer_pulse);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == HI_ADDR && !xfer_pulse) |=> (result_q == '0));

  p_done_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> rd_valid);

  p_other_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || (rd_addr != LO_ADDR && rd_addr != HI_ADDR)) |=> (!rd_valid && !rd_done));
endmodule

bind field_corr_detect fcd_checker #(
  .CMP_W(CMP_W), .ACC_W(ACC_W), .RES_W(RES_W), .ADDR_W(ADDR_W),
  .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .xfer_pulse(xfer_pulse), .pix_valid(pix_valid),
  .acc_sum(acc_sum), .result_q(result_q), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_done(rd_done)
);

// File: tb/sim_field_corr_detect.sv
module sim_field_corr_detect;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, active_vid, fld_strobe, rd_en;
  logic [7:0] luma_a, luma_b, rd_addr;
  logic [7:0] rd_data;
  logic       rd_valid, rd_done;

  field_corr_detect u0 (
    .clk(clk), .rst(rst), .active_vid(active_vid), .luma_a(luma_a), .luma_b(luma_b),
    .fld_strobe(fld_strobe), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
  );

  int checks = 0;
  int errors = 0;
  int unsigned sum = 0;
  logic [15:0] exp_res = '0;

  logic [7:0] exp_q[$];
  logic       done_q[$];
  string      tag_q[$];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int absd(logic [7:0] a, logic [7:0] b);
    int x = int'(a[7:4]);
    int y = int'(b[7:4]);
    return (x > y) ? x - y : y - x;
  endfunction

  // monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected read data", rd_data, 0);
      end else begin
        logic [7:0] e;
        logic       d;
        string      t;
        e = exp_q.pop_front();
        d = done_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
        check(rd_done == d, {t, " rd_done"}, rd_done, d);
      end
    end
  end

  task automatic pixel(logic [7:0] a, logic [7:0] b, logic act);
    @(negedge clk);
    luma_a = a; luma_b = b; active_vid = act;
    if (act) sum += absd(a, b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      active_vid = 1'b0;
    end
  endtask

  task automatic rd(logic [7:0] addr, logic [7:0] exp, logic done, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    exp_q.push_back(exp); done_q.push_back(done); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_none(logic [7:0] addr, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid == 1'b0 && rd_done == 1'b0, tag, {rd_valid, rd_done}, 0);
  endtask

  task automatic field_end();
    idle(3);
    exp_res = 16'(sum >> 6);
    sum = 0;
    @(negedge clk) fld_strobe = 1'b1;
    repeat (4) @(negedge clk);
    fld_strobe = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; active_vid = 1'b0; fld_strobe = 1'b0; rd_en = 1'b0;
    luma_a = '0; luma_b = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: outputs and result are zero after reset
    check(rd_valid == 0 && rd_done == 0 && rd_data == 0, "R10 reset outputs",
          {rd_valid, rd_done, rd_data}, 0);
    rd(8'h80, 8'h00, 1'b0, "R10 low byte after reset");
    rd(8'h81, 8'h00, 1'b1, "R10 high byte after reset");

    // R2/R6/R7/R8: mixed pattern field
    pixel(8'hF0, 8'h00, 1'b1);
    pixel(8'h00, 8'hF0, 1'b1);
    pixel(8'h3F, 8'h30, 1'b1);
    pixel(8'h5A, 8'hA5, 1'b1);
    for (int i = 0; i < 1500; i++)
      pixel(8'((i * 37) ^ (i >> 2)), 8'((i * 91) + 5), 1'b1);
    field_end();
    rd(8'h80, exp_res[7:0], 1'b0, "R6 low byte");
    rd(8'h80, exp_res[7:0], 1'b0, "R8 low byte read twice");
    rd_none(8'h7F, "R9 address 0x7F");
    rd_none(8'h82, "R9 address 0x82");
    rd_none(8'h00, "R9 address 0x00");
    rd(8'h80, exp_res[7:0], 1'b0, "R9 result unchanged by other addresses");
    rd(8'h81, exp_res[15:8], 1'b1, "R7 high byte");
    rd(8'h80, 8'h00, 1'b0, "R7 low byte cleared after high read");
    rd(8'h81, 8'h00, 1'b1, "R7 high byte cleared after high read");

    // R2: lower nibble differences contribute nothing
    for (int i = 0; i < 200; i++) pixel(8'h7F, 8'h70, 1'b1);
    field_end();
    rd(8'h80, 8'h00, 1'b0, "R2 low nibble ignored");
    rd(8'h81, 8'h00, 1'b1, "R2 low nibble ignored high");

    // R1: blanked pixels ignored, 64 active max pixels give 15
    for (int i = 0; i < 300; i++) pixel(8'hFF, 8'h00, 1'b0);
    for (int i = 0; i < 64; i++)  pixel(8'hFF, 8'h0F, 1'b1);
    for (int i = 0; i < 300; i++) pixel(8'h00, 8'hF0, 1'b0);
    field_end();
    rd(8'h80, 8'd15, 1'b0, "R1 blanked pixels ignored");
    rd(8'h81, 8'h00, 1'b1, "R1 high byte");

    // R3: large field, no wrap
    for (int i = 0; i < 20000; i++) pixel((i % 2) ? 8'hF3 : 8'h0C, (i % 2) ? 8'h01 : 8'hFE, 1'b1);
    field_end();
    check(exp_res == 16'h124F, "R3 model value", exp_res, 16'h124F);
    rd(8'h80, 8'h4F, 1'b0, "R3 low byte of large field");
    rd(8'h81, 8'h12, 1'b1, "R3 high byte of large field");

    // R4: next field restarts from zero
    for (int i = 0; i < 128; i++) pixel(8'h80, 8'h00, 1'b1);
    field_end();
    rd(8'h80, 8'd16, 1'b0, "R4 sum restarted after transfer");
    rd(8'h81, 8'h00, 1'b1, "R4 high byte");

    // R5: long strobe gives one transfer only
    for (int i = 0; i < 640; i++) pixel(8'hA0, 8'h00, 1'b1);
    idle(3);
    exp_res = 16'(sum >> 6); sum = 0;
    @(negedge clk) fld_strobe = 1'b1;
    repeat (5) @(negedge clk);
    rd(8'h80, exp_res[7:0], 1'b0, "R5 result readable while strobe high");
    rd(8'h81, exp_res[15:8], 1'b1, "R5 high byte while strobe high");
    for (int i = 0; i < 128; i++) pixel(8'hF0, 8'h00, 1'b1);
    idle(4);
    rd(8'h80, 8'h00, 1'b0, "R5 no second transfer while held high");
    @(negedge clk) fld_strobe = 1'b0;
    idle(3);
    field_end();
    rd(8'h80, 8'd30, 1'b0, "R5 pixels during held strobe kept for next field");
    rd(8'h81, 8'h00, 1'b1, "R5 high byte next field");

    // R11: high-byte read on the transfer edge
    for (int i = 0; i < 2000; i++) pixel(8'hF0, 8'h10, 1'b1);
    field_end();
    for (int i = 0; i < 3000; i++) pixel(8'h20, 8'hE0, 1'b1);
    idle(3);
    @(negedge clk) fld_strobe = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h81;
    exp_q.push_back(exp_res[15:8]); done_q.push_back(1'b1); tag_q.push_back("R11 old high byte on collision");
    exp_res = 16'(sum >> 6); sum = 0;
    @(negedge clk) rd_en = 1'b0;
    repeat (3) @(negedge clk);
    fld_strobe = 1'b0;
    idle(3);
    rd(8'h80, exp_res[7:0], 1'b0, "R11 new low byte kept");
    rd(8'h81, exp_res[15:8], 1'b1, "R11 new high byte kept");

    idle(3);
    check(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule